// File: doc/BRIEF.md
# Dual-Protocol Parallel Display Write Master

This block is the host side of an 8-bit parallel link to a display controller. It takes one byte at a time from a valid/ready request port, together with a flag that says whether the byte is pixel data or a command. It then runs one complete, timed write cycle on the bus: chip select, the data/command line, the two control strobes, the data byte and an output-enable for an external bidirectional pad.

A strap input picks the strobe protocol. In the 6800-style protocol, one control line is a read/write select held low for the write, and the other is an enable that pulses high. In the 8080-style protocol, the first line is a write strobe that pulses low, and the second is a read strobe that stays high. Every timing minimum is given as a parameter in picoseconds and converted to whole clock cycles, rounded up, at elaboration. These minimums are the whole-cycle time, the strobe-active and strobe-inactive widths, data setup, and data and address hold. The request port stays not-ready until the whole-cycle minimum has passed, so requests that arrive back to back are spaced correctly without help from the requester. The strap is sampled only when a request is accepted.

With the defaults (8 ns clock) the derived counts are as follows: setup N_SU = 1, strobe N_ACT = 13, hold N_HLD = 2, minimum inactive N_INACT = 13, busy time N_BUSY = 38. The busy time covers the 300 ns cycle minimum.

Top module: `dpb_master`

## Requirements
- R1: After reset the port reports ready, chip select is high and the data output enable is low. Both control lines show the 6800 idle levels: the read/write select is high and the enable is low.
- R2: The data/command pin equals the request flag (1 = display data, 0 = command) on every cycle of the chip-select-low window.
- R3: Each accepted request produces exactly one contiguous chip-select-low window of N_SU + N_ACT + N_HLD cycles.
- R4: With mode_i = 0 (6800), the read/write select (bus_rwn_wrn_o) is low throughout the chip-select-low window. The enable (bus_en_rdn_o) is high for exactly N_ACT cycles, beginning N_SU cycles after chip select falls.
- R5: With mode_i = 1 (8080), the write strobe (bus_rwn_wrn_o) is low for exactly N_ACT cycles, beginning N_SU cycles after chip select falls. The read strobe (bus_en_rdn_o) stays high during the transfer and while idle. In 8080 idle both lines are high.
- R6: Throughout the chip-select-low window the data output enable is high and the data bus carries the accepted byte.
- R7: The active strobe lasts no less than either the strobe-width minimum or the data-setup minimum, rounded up to whole clocks (13 cycles, 104 ns, at the defaults).
- R8: After acceptance, ready stays low for exactly N_BUSY cycles, and N_BUSY clocks cover the cycle-time minimum. A request held valid is accepted again N_BUSY + 1 cycles after the first.
- R9: Between two strobes the strobe is inactive for no fewer than N_INACT cycles.
- R10: The protocol strap is taken at acceptance. A change while a transfer runs leaves that transfer unchanged and applies to the next one.
- R11: After the strobe's terminating edge, chip select stays low and the data stays unchanged for N_HLD cycles (at least 15 ns).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | Protocol strap: 0 = 6800-style, 1 = 8080-style |
| req_valid_i | input | 1 | Request holds a byte |
| req_ready_o | output | 1 | Engine idle, request will be taken this cycle |
| req_data_i | input | DATA_W | Byte to send |
| req_is_data_i | input | 1 | 1 = display data, 0 = command |
| bus_cs_n_o | output | 1 | Chip select, active low |
| bus_a0_o | output | 1 | Data/command select |
| bus_rwn_wrn_o | output | 1 | 6800: read/write select; 8080: write strobe (active low) |
| bus_en_rdn_o | output | 1 | 6800: enable strobe (active high); 8080: read strobe (active low) |
| bus_d_o | output | DATA_W | Data bus output value |
| bus_d_oe_o | output | 1 | Output enable for the external data pad |

## Verification
The embedded properties watch, on every cycle, the invariants of a running transfer. Ready drops after acceptance, and the strap copy does not move while the engine is busy. A0 and the data stay stable under chip select. The read line stays high in 8080 mode, and the select is low whenever the 6800 enable is high. A counter measures each strobe width against N_ACT and each inactive gap against N_INACT. Only the directed scenarios can show the absolute phase placement: where the strobe sits inside the chip-select window, the exact hold length after it, the exact busy length and back-to-back spacing, the idle levels of each protocol, and whether a mid-transfer strap change is deferred to the following byte.

// File: rtl/dpb_pkg.sv
package dpb_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_RECOVER
    } phase_e;

    typedef enum logic {
        BUS_M68 = 1'b0,
        BUS_I80 = 1'b1
    } bus_mode_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dpb_seq.sv
module dpb_seq
    import dpb_pkg::*;
#(
    parameter int N_SU  = 1,
    parameter int N_ACT = 13,
    parameter int N_HLD = 2,
    parameter int N_REC = 22,
    parameter int CNT_W = 5
) (
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   valid_i,
    output logic   ready_o,
    output logic   accept_o,
    output phase_e phase_o
);

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
    } seq_s;

    seq_s seq_d, seq_q;

    assign ready_o  = (seq_q.phase == PH_IDLE);
    assign accept_o = valid_i && ready_o;
    assign phase_o  = seq_q.phase;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (valid_i) begin
                    seq_d.phase = PH_SETUP;
                    seq_d.cnt   = CNT_W'(N_SU - 1);
                end
            end
            PH_SETUP: begin
                if (seq_q.cnt == '0) begin
                    seq_d.phase = PH_STROBE;
                    seq_d.cnt   = CNT_W'(N_ACT - 1);
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.phase = PH_HOLD;
                    seq_d.cnt   = CNT_W'(N_HLD - 1);
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                if (seq_q.cnt == '0) begin
                    seq_d.phase = PH_RECOVER;
                    seq_d.cnt   = CNT_W'(N_REC - 1);
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            PH_RECOVER: begin
                if (seq_q.cnt == '0) begin
                    seq_d.phase = PH_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            default: begin
                seq_d.phase = PH_IDLE;
                seq_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seq_q.phase <= PH_IDLE;
            seq_q.cnt   <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    // R8
    busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_o |=> !ready_o);

endmodule

// File: rtl/dpb_capture.sv
module dpb_capture
    import dpb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              idle_i,
    input  logic              accept_i,
    input  logic              mode_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              is_data_i,
    output bus_mode_e         mode_o,
    output logic              a0_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        bus_mode_e         mode;
        logic              a0;
        logic [DATA_W-1:0] data;
    } cap_s;

    cap_s cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (idle_i) begin
            cap_d.mode = bus_mode_e'(mode_i);
        end
        if (accept_i) begin
            cap_d.a0   = is_data_i;
            cap_d.data = data_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cap_q.mode <= BUS_M68;
            cap_q.a0   <= 1'b0;
            cap_q.data <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign mode_o = cap_q.mode;
    assign a0_o   = cap_q.a0;
    assign data_o = cap_q.data;

    // R10
    mode_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !idle_i |=> $stable(mode_o));

endmodule

// File: rtl/dpb_pinmap.sv
module dpb_pinmap
    import dpb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  phase_e            phase_i,
    input  bus_mode_e         mode_i,
    input  logic              a0_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              cs_n_o,
    output logic              a0_o,
    output logic              ctl_a_o,
    output logic              ctl_b_o,
    output logic [DATA_W-1:0] d_o,
    output logic              oe_o
);

    typedef struct packed {
        logic              cs_n;
        logic              a0;
        logic              ctl_a;
        logic              ctl_b;
        logic              oe;
        logic [DATA_W-1:0] d;
    } pin_s;

    pin_s pin_d, pin_q;
    logic selected;
    logic strobing;

    always_comb begin
        selected = (phase_i == PH_SETUP) || (phase_i == PH_STROBE) || (phase_i == PH_HOLD);
        strobing = (phase_i == PH_STROBE);
        pin_d.cs_n = !selected;
        pin_d.a0   = a0_i;
        pin_d.oe   = selected;
        pin_d.d    = data_i;
        if (mode_i == BUS_I80) begin
            pin_d.ctl_a = !strobing;
            pin_d.ctl_b = 1'b1;
        end else begin
            pin_d.ctl_a = !selected;
            pin_d.ctl_b = strobing;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pin_q.cs_n  <= 1'b1;
            pin_q.a0    <= 1'b0;
            pin_q.ctl_a <= 1'b1;
            pin_q.ctl_b <= 1'b0;
            pin_q.oe    <= 1'b0;
            pin_q.d     <= '0;
        end else begin
            pin_q <= pin_d;
        end
    end

    assign cs_n_o  = pin_q.cs_n;
    assign a0_o    = pin_q.a0;
    assign ctl_a_o = pin_q.ctl_a;
    assign ctl_b_o = pin_q.ctl_b;
    assign oe_o    = pin_q.oe;
    assign d_o     = pin_q.d;

    // R2
    a0_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cs_n_o |=> (cs_n_o || $stable(a0_o)));

    // R6
    data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cs_n_o |=> (cs_n_o || $stable(d_o)));

endmodule

// File: rtl/dpb_master.sv
module dpb_master
    import dpb_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int CLK_PS       = 8000,
    parameter int T_CYCLE_PS   = 300000,
    parameter int T_ACTIVE_PS  = 100000,
    parameter int T_IDLE_PS    = 100000,
    parameter int T_DSETUP_PS  = 40000,
    parameter int T_DHOLD_PS   = 15000,
    parameter int T_ASETUP_PS  = 0,
    parameter int T_AHOLD_PS   = 0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              mode_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [DATA_W-1:0] req_data_i,
    input  logic              req_is_data_i,
    output logic              bus_cs_n_o,
    output logic              bus_a0_o,
    output logic              bus_rwn_wrn_o,
    output logic              bus_en_rdn_o,
    output logic [DATA_W-1:0] bus_d_o,
    output logic              bus_d_oe_o
);

    localparam int N_SU    = max2(1, ceil_div(T_ASETUP_PS, CLK_PS));
    localparam int N_ACT   = max2(1, max2(ceil_div(T_ACTIVE_PS, CLK_PS),
                                          ceil_div(T_DSETUP_PS, CLK_PS)));
    localparam int N_HLD   = max2(1, max2(ceil_div(T_DHOLD_PS, CLK_PS),
                                          ceil_div(T_AHOLD_PS, CLK_PS)));
    localparam int N_INACT = ceil_div(T_IDLE_PS, CLK_PS);
    localparam int N_CYC   = ceil_div(T_CYCLE_PS, CLK_PS);
    localparam int N_TAIL  = max2(max2(N_CYC - N_SU - N_ACT, N_INACT - N_SU), N_HLD + 1);
    localparam int N_REC   = N_TAIL - N_HLD;
    localparam int CNT_W   = $clog2(max2(max2(N_ACT, N_TAIL), N_SU) + 1);
    localparam int GAP_W   = $clog2(N_INACT + 2);

    phase_e            phase;
    bus_mode_e         mode_q;
    logic              accept;
    logic              cap_a0;
    logic [DATA_W-1:0] cap_data;

    dpb_seq #(
        .N_SU  (N_SU),
        .N_ACT (N_ACT),
        .N_HLD (N_HLD),
        .N_REC (N_REC),
        .CNT_W (CNT_W)
    ) i_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .valid_i  (req_valid_i),
        .ready_o  (req_ready_o),
        .accept_o (accept),
        .phase_o  (phase)
    );

    dpb_capture #(
        .DATA_W (DATA_W)
    ) i_capture (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .idle_i    (req_ready_o),
        .accept_i  (accept),
        .mode_i    (mode_i),
        .data_i    (req_data_i),
        .is_data_i (req_is_data_i),
        .mode_o    (mode_q),
        .a0_o      (cap_a0),
        .data_o    (cap_data)
    );

    dpb_pinmap #(
        .DATA_W (DATA_W)
    ) i_pinmap (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .phase_i (phase),
        .mode_i  (mode_q),
        .a0_i    (cap_a0),
        .data_i  (cap_data),
        .cs_n_o  (bus_cs_n_o),
        .a0_o    (bus_a0_o),
        .ctl_a_o (bus_rwn_wrn_o),
        .ctl_b_o (bus_en_rdn_o),
        .d_o     (bus_d_o),
        .oe_o    (bus_d_oe_o)
    );

    // Strobe width and gap monitors feeding the properties below.
    logic             stb_act;
    logic             stb_act_q;
    logic [CNT_W-1:0] stb_len_q;
    logic [GAP_W-1:0] gap_q;

    assign stb_act = !bus_cs_n_o &&
                     ((mode_q == BUS_M68) ? bus_en_rdn_o : !bus_rwn_wrn_o);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            stb_act_q <= 1'b0;
            stb_len_q <= '0;
            gap_q     <= GAP_W'(N_INACT);
        end else begin
            stb_act_q <= stb_act;
            stb_len_q <= stb_act ? stb_len_q + 1'b1 : '0;
            if (stb_act) begin
                gap_q <= '0;
            end else if (gap_q != GAP_W'(N_INACT)) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    // R7
    strobe_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stb_act_q && !stb_act) |-> (stb_len_q == CNT_W'(N_ACT)));

    // R9
    strobe_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!stb_act_q && stb_act) |-> (gap_q >= GAP_W'(N_INACT)));

    // R4
    m68_select_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bus_cs_n_o && mode_q == BUS_M68 && bus_en_rdn_o) |-> !bus_rwn_wrn_o);

    // R5
    i80_read_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bus_cs_n_o && mode_q == BUS_I80) |-> bus_en_rdn_o);

endmodule

// File: tb/test_dpb_master.sv
`timescale 1ns/1ps
module test_dpb_master;

    localparam int CLK = 8000;
    function automatic int cdiv(input int n, input int d);
        return (n + d - 1) / d;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
    localparam int B_SU    = 1;
    localparam int B_ACT   = mx(cdiv(100000, CLK), cdiv(40000, CLK));
    localparam int B_HLD   = mx(1, cdiv(15000, CLK));
    localparam int B_INACT = cdiv(100000, CLK);
    localparam int B_CYC   = cdiv(300000, CLK);
    localparam int B_BUSY  = B_SU + B_ACT + mx(mx(B_CYC - B_SU - B_ACT, B_INACT - B_SU), B_HLD + 1);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode = 1'b0;
    logic       valid = 1'b0;
    logic [7:0] data = 8'h00;
    logic       is_data = 1'b0;
    logic       ready, cs_n, a0, ctl_a, ctl_b, oe;
    logic [7:0] d;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dpb_master i_dpb_master (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .mode_i        (mode),
        .req_valid_i   (valid),
        .req_ready_o   (ready),
        .req_data_i    (data),
        .req_is_data_i (is_data),
        .bus_cs_n_o    (cs_n),
        .bus_a0_o      (a0),
        .bus_rwn_wrn_o (ctl_a),
        .bus_en_rdn_o  (ctl_b),
        .bus_d_o       (d),
        .bus_d_oe_o    (oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!ready) @(negedge clk);
    endtask

    // One transfer; m: 0 = 6800, 1 = 8080. flip_at > 0 toggles the strap at that cycle.
    task automatic xfer(input logic m, input logic isd, input logic [7:0] b, input int flip_at);
        int cs_first = -1, cs_cnt = 0, cs_last = -1;
        int st_first = -1, st_cnt = 0, st_last = -1;
        int busy = 0, bad_a0 = 0, bad_d = 0, bad_rw = 0, bad_rd = 0;
        logic stb;
        wait_idle();
        mode = m; valid = 1'b1; data = b; is_data = isd;
        @(posedge clk);
        for (int k = 1; k <= B_BUSY + 4; k++) begin
            @(negedge clk);
            if (k == 1) valid = 1'b0;
            if (k == flip_at) mode = ~m;
            if (!ready) busy++;
            if (!cs_n) begin
                if (cs_first < 0) cs_first = k;
                cs_cnt++; cs_last = k;
                if (a0 !== isd) bad_a0++;
                if (d !== b || oe !== 1'b1) bad_d++;
                if (m == 1'b0 && ctl_a !== 1'b0) bad_rw++;
                if (m == 1'b1 && ctl_b !== 1'b1) bad_rd++;
            end
            stb = m ? !ctl_a : ctl_b;
            if (stb) begin
                if (st_first < 0) st_first = k;
                st_cnt++; st_last = k;
            end
        end
        check(cs_cnt == B_SU + B_ACT + B_HLD, "R3 cs window length", cs_cnt, B_SU + B_ACT + B_HLD);
        check(cs_last - cs_first + 1 == cs_cnt, "R3 cs window contiguous", cs_last - cs_first + 1, cs_cnt);
        check(bad_a0 == 0, "R2 a0 equals flag", bad_a0, 0);
        check(bad_d == 0, "R6 data driven under cs", bad_d, 0);
        check(st_cnt == B_ACT, m ? "R5 wr strobe width" : "R4 enable width", st_cnt, B_ACT);
        check(st_first - cs_first == B_SU, m ? "R5 strobe offset" : "R4 strobe offset", st_first - cs_first, B_SU);
        check(st_cnt * CLK >= 100000 && st_cnt * CLK >= 40000, "R7 strobe min ps", st_cnt * CLK, 100000);
        check(cs_last - st_last == B_HLD, "R11 hold after strobe", cs_last - st_last, B_HLD);
        check(busy == B_BUSY, "R8 ready low cycles", busy, B_BUSY);
        check(B_BUSY * CLK >= 300000, "R8 busy covers cycle time", B_BUSY * CLK, 300000);
        if (m == 1'b0) check(bad_rw == 0, "R4 rw low under cs", bad_rw, 0);
        else check(bad_rd == 0, "R5 rd high under cs", bad_rd, 0);
        if (flip_at > 0) check(st_cnt == B_ACT && bad_rd == 0 && bad_rw == 0,
                               "R10 transfer keeps accepted mode", st_cnt, B_ACT);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready === 1'b1, "R1 ready after reset", int'(ready), 1);
        check(cs_n === 1'b1 && oe === 1'b0, "R1 cs high oe low", int'({cs_n, oe}), 2);
        check(ctl_a === 1'b1 && ctl_b === 1'b0, "R1 6800 idle levels", int'({ctl_a, ctl_b}), 2);
    endtask

    task automatic t_m68();
        xfer(1'b0, 1'b1, 8'hA5, 0);
        xfer(1'b0, 1'b0, 8'h3C, 0);
        repeat (2) @(negedge clk);
        check(ctl_a === 1'b1 && ctl_b === 1'b0, "R4 6800 idle levels", int'({ctl_a, ctl_b}), 2);
    endtask

    task automatic t_i80();
        xfer(1'b1, 1'b1, 8'h5A, 0);
        xfer(1'b1, 1'b0, 8'hFF, 0);
        repeat (2) @(negedge clk);
        check(ctl_a === 1'b1 && ctl_b === 1'b1, "R5 8080 idle levels", int'({ctl_a, ctl_b}), 3);
    endtask

    task automatic t_mode_flip();
        // strap moves from 8080 to 6800 mid-transfer; next byte must be 6800-shaped
        xfer(1'b1, 1'b1, 8'h81, 6);
        xfer(1'b0, 1'b1, 8'h18, 0);
        check(mode === 1'b0, "R10 next transfer took new strap", int'(mode), 0);
    endtask

    task automatic t_back_to_back();
        int s1 = -1, s2 = -1, gap = 0, last_end = -1, acc2 = -1;
        logic [7:0] d1 = 8'h00, d2 = 8'h00;
        logic prev = 1'b0, stb;
        wait_idle();
        mode = 1'b0; valid = 1'b1; data = 8'hC3; is_data = 1'b1;
        @(posedge clk);
        for (int k = 1; k <= 2 * B_BUSY + 8; k++) begin
            @(negedge clk);
            if (k == 1) data = 8'h7E;
            if (acc2 > 0 && k == acc2 + 1) valid = 1'b0;
            if (ready && acc2 < 0 && k > 1) acc2 = k;
            stb = !cs_n && ctl_b;
            if (stb && !prev) begin
                if (s1 < 0) begin s1 = k; d1 = d; end
                else if (s2 < 0) begin s2 = k; d2 = d; gap = k - last_end - 1; end
            end
            if (!stb && prev) last_end = k - 1;
            prev = stb;
        end
        valid = 1'b0;
        check(s2 - s1 == B_BUSY + 1, "R8 back-to-back spacing", s2 - s1, B_BUSY + 1);
        check(gap >= B_INACT, "R9 inactive gap", gap, B_INACT);
        check(d1 == 8'hC3 && d2 == 8'h7E, "R6 both bytes on bus", int'({d1, d2}), 16'hC37E);
    endtask

    initial begin
        t_reset();
        t_m68();
        t_i80();
        t_mode_flip();
        t_back_to_back();
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule